// File: doc/BRIEF.md
# Command/Response Status and Data Port

This block is the device side of a byte-wide register window used by a host to talk to a command/response coprocessor. The host writes a command into a byte FIFO port, one byte per access, and later reads the response back from the same port. A status byte and a 16-bit burst count tell the host when a transfer can proceed and how many bytes it may move without polling again.

The command carries its own length as a big-endian 32-bit field in bytes 2 to 5. The block watches that field and drops its expect flag once the whole command has arrived. A write to the go bit hands the buffered command to an execution engine. The engine reads the command through a random-access port, writes the response into a second buffer, and signals completion with the response length. The host then drains the response through the FIFO port. It can rewind the response with the retry bit, or abandon execution through a cancel bit.

Register offsets used by the block are as follows. The status byte is at 0x18. The burst count is at 0x19 (low byte) and 0x1A (high byte). The cancel bit is bit 0 of the byte at 0x1B. The data FIFO is at 0x24. Any other offset reads 0. Status bits are: 7 valid, 6 ready, 5 go (write only, reads 0), 4 data available, 3 expect, 1 retry (write only).

Top module: `cmdport_top`

## Requirements
- R1: After reset the status byte reads 0x80, both burst count bytes read 0, and neither eng_start nor eng_cancel is high.
- R2: A status write with bit 6 set puts the block into command reception from any state, with no bytes held. While receiving, status bit 6 reads 1; in every other state it reads 0.
- R3: A FIFO write stores one byte at the next command position. It is accepted only in reception, and only when no byte is held yet or expect (status bit 3) is 1. Writes at any other time are ignored. The count of held bytes never exceeds the buffer depth (default 1280).
- R4: Expect reads 1 when at least one byte is held, fewer than depth bytes are held, and the held count is below 6 or below the big-endian length in bytes 2 to 5 (byte 2 most significant). Otherwise it reads 0.
- R5: While FIFO writes are accepted, the burst count equals depth minus the held byte count. Once the command is complete it reads 0.
- R6: A status write with bit 5 set, bit 6 clear, at least one byte held and expect 0 starts execution. eng_start is then high for exactly the following cycle and eng_cmd_len equals the held byte count. In any other situation the go bit is ignored.
- R7: During execution, status bits 6, 4 and 3 and the burst count read 0. Engine response writes are accepted only during execution. eng_done moves the block to response readout with length min(eng_rsp_len, depth).
- R8: In readout, status bit 4 is 1 while unread bytes remain and the burst count equals the remaining bytes. A FIFO read returns the next response byte and advances. A FIFO read with nothing left returns 0 and does not advance.
- R9: A status write with bit 1 set, bits 6 and 5 clear, during readout rewinds the response to its first byte. At any other time it has no effect.
- R10: Writing 1 to bit 0 of the byte at offset 0x1B during execution returns the block to idle (status 0x80), and eng_cancel is high for the following cycle. At any other time the write has no effect.
- R11: When several command bits are written in one status write, ready takes precedence over go, and go over retry.
- R12: eng_cmd_rdata returns the command byte stored at eng_cmd_raddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host byte write strobe |
| reg_rd | input | 1 | Host byte read strobe (pops the FIFO) |
| reg_addr | input | ADDR_W | Host byte offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr (combinational) |
| eng_start | output | 1 | One-cycle pulse: command ready for execution |
| eng_cancel | output | 1 | One-cycle pulse: execution abandoned |
| eng_cmd_len | output | 16 | Number of command bytes held |
| eng_cmd_raddr | input | PW | Engine command read index |
| eng_cmd_rdata | output | 8 | Command byte at eng_cmd_raddr |
| eng_rsp_we | input | 1 | Engine response byte write |
| eng_rsp_waddr | input | PW | Response byte index |
| eng_rsp_wdata | input | 8 | Response byte |
| eng_done | input | 1 | Engine finished; response is complete |
| eng_rsp_len | input | 16 | Response length, sampled with eng_done |

## Verification
The assertions assume the host issues at most one byte access per cycle. They also assume that eng_done arrives only after the engine has written every response byte it declares. The bench's engine stub writes each response in full before raising eng_done, and it fills every buffer position before that position is read. A cancel write and eng_done never come in the same cycle, and neither does a ready write together with a cancel. The stimulus keeps to one strobe per cycle throughout.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } cp_state_e;

    // byte offsets inside the host window
    localparam int OFS_STS    = 'h18;
    localparam int OFS_BURSTL = 'h19;
    localparam int OFS_BURSTH = 'h1A;
    localparam int OFS_CANCEL = 'h1B;
    localparam int OFS_FIFO   = 'h24;

    // status byte bit positions
    localparam int B_VALID  = 7;
    localparam int B_READY  = 6;
    localparam int B_GO     = 5;
    localparam int B_DATA   = 4;
    localparam int B_EXPECT = 3;
    localparam int B_RETRY  = 1;
    localparam int B_CANCEL = 0;

    // header bytes holding the big-endian length
    localparam int LEN_FIRST = 2;
    localparam int LEN_LAST  = 5;

endpackage

// File: rtl/cmdport_buf.sv
module cmdport_buf #(
    parameter int DEPTH = 1280,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr <= LAST)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (raddr <= LAST) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/cmdport_burst.sv
module cmdport_burst #(
    parameter int DEPTH = 1280,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          rx_open,
    input  logic          rsp_mode,
    input  logic [CW-1:0] cmd_cnt,
    input  logic [CW-1:0] rsp_len,
    input  logic [CW-1:0] rsp_ptr,
    output logic [15:0]   burst
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] space;
    logic [CW-1:0] remain;

    assign space  = DEPTH_C - cmd_cnt;
    assign remain = rsp_len - rsp_ptr;

    always_comb begin
        burst = 16'd0;
        if (rx_open) begin
            burst = 16'(space);
        end else if (rsp_mode) begin
            burst = 16'(remain);
        end
    end

endmodule

// File: rtl/cmdport_top.sv
module cmdport_top
    import cmdport_pkg::*;
#(
    parameter int DEPTH  = 1280,
    parameter int ADDR_W = 12,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_start,
    output logic              eng_cancel,
    output logic [15:0]       eng_cmd_len,
    input  logic [PW-1:0]     eng_cmd_raddr,
    output logic [7:0]        eng_cmd_rdata,
    input  logic              eng_rsp_we,
    input  logic [PW-1:0]     eng_rsp_waddr,
    input  logic [7:0]        eng_rsp_wdata,
    input  logic              eng_done,
    input  logic [15:0]       eng_rsp_len
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HDR_C   = CW'(LEN_LAST + 1);

    typedef struct packed {
        cp_state_e     st;
        logic [CW-1:0] cnt;
        logic [31:0]   len;
        logic [CW-1:0] rlen;
        logic [CW-1:0] rptr;
        logic          start;
        logic          cancel;
    } ctl_t;

    ctl_t q, d;

    logic          sts_wr, cancel_wr, fifo_wr, fifo_rd;
    logic          need_more, expect_b, accept, rsp_avail;
    logic [7:0]    sts_byte, fifo_byte, rsp_rdata;
    logic [15:0]   burst;

    assign sts_wr    = reg_wr && (reg_addr == ADDR_W'(OFS_STS));
    assign cancel_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CANCEL)) && reg_wdata[B_CANCEL];
    assign fifo_wr   = reg_wr && (reg_addr == ADDR_W'(OFS_FIFO));
    assign fifo_rd   = reg_rd && (reg_addr == ADDR_W'(OFS_FIFO));

    assign need_more = (q.cnt < HDR_C) || (32'(q.cnt) < q.len);
    assign expect_b  = (q.st == ST_RX) && (q.cnt != '0) && (q.cnt != DEPTH_C) && need_more;
    assign accept    = (q.st == ST_RX) && ((q.cnt == '0) || expect_b);
    assign rsp_avail = (q.st == ST_DONE) && (q.rptr < q.rlen);

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.cancel = 1'b0;

        // command bits: ready > go > retry
        if (sts_wr && reg_wdata[B_READY]) begin
            d.st  = ST_RX;
            d.cnt = '0;
            d.len = '0;
        end else if (sts_wr && reg_wdata[B_GO]) begin
            if ((q.st == ST_RX) && (q.cnt != '0) && !expect_b) begin
                d.st    = ST_EXEC;
                d.start = 1'b1;
            end
        end else if (sts_wr && reg_wdata[B_RETRY]) begin
            if (q.st == ST_DONE) begin
                d.rptr = '0;
            end
        end

        if (fifo_wr && accept) begin
            d.cnt = q.cnt + CW'(1);
            if ((q.cnt >= CW'(LEN_FIRST)) && (q.cnt <= CW'(LEN_LAST))) begin
                d.len = {q.len[23:0], reg_wdata};
            end
        end

        if (fifo_rd && rsp_avail) begin
            d.rptr = q.rptr + CW'(1);
        end

        if ((q.st == ST_EXEC) && eng_done) begin
            d.st   = ST_DONE;
            d.rptr = '0;
            d.rlen = (eng_rsp_len > 16'(DEPTH)) ? DEPTH_C : CW'(eng_rsp_len);
        end

        if (cancel_wr && (q.st == ST_EXEC)) begin
            d.st     = ST_IDLE;
            d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    cmdport_buf #(.DEPTH(DEPTH)) u_cmd_buf (
        .clk   (clk),
        .we    (fifo_wr && accept),
        .waddr (q.cnt[PW-1:0]),
        .wdata (reg_wdata),
        .raddr (eng_cmd_raddr),
        .rdata (eng_cmd_rdata)
    );

    cmdport_buf #(.DEPTH(DEPTH)) u_rsp_buf (
        .clk   (clk),
        .we    (eng_rsp_we && (q.st == ST_EXEC)),
        .waddr (eng_rsp_waddr),
        .wdata (eng_rsp_wdata),
        .raddr (q.rptr[PW-1:0]),
        .rdata (rsp_rdata)
    );

    cmdport_burst #(.DEPTH(DEPTH)) u_burst (
        .rx_open  (accept),
        .rsp_mode (q.st == ST_DONE),
        .cmd_cnt  (q.cnt),
        .rsp_len  (q.rlen),
        .rsp_ptr  (q.rptr),
        .burst    (burst)
    );

    always_comb begin
        sts_byte           = 8'h00;
        sts_byte[B_VALID]  = 1'b1;
        sts_byte[B_READY]  = (q.st == ST_RX);
        sts_byte[B_DATA]   = rsp_avail;
        sts_byte[B_EXPECT] = expect_b;
    end

    assign fifo_byte = rsp_avail ? rsp_rdata : 8'h00;

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_W'(OFS_STS)) begin
            reg_rdata = sts_byte;
        end else if (reg_addr == ADDR_W'(OFS_BURSTL)) begin
            reg_rdata = burst[7:0];
        end else if (reg_addr == ADDR_W'(OFS_BURSTH)) begin
            reg_rdata = burst[15:8];
        end else if (reg_addr == ADDR_W'(OFS_FIFO)) begin
            reg_rdata = fifo_byte;
        end
    end

    assign eng_start   = q.start;
    assign eng_cancel  = q.cancel;
    assign eng_cmd_len = 16'(q.cnt);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= DEPTH_C); // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R6
    AST_EXEC_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC) |-> (burst == 16'd0)); // R7
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.rptr <= q.rlen); // R8
    AST_DRAINED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_DONE) && (burst == 16'd0)) |-> !sts_byte[B_DATA]); // R8
    AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_DONE) && sts_wr && reg_wdata[B_RETRY] && !reg_wdata[B_READY]
         && !reg_wdata[B_GO] && !eng_done) |=> (q.rptr == '0)); // R9
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cancel |-> (q.st == ST_IDLE)); // R10

endmodule

// File: tb/cmdport_top_tb.sv
module cmdport_top_tb_top;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 1280;
    localparam int PW     = $clog2(DEPTH);
    localparam int A_STS  = 'h18;
    localparam int A_BL   = 'h19;
    localparam int A_BH   = 'h1A;
    localparam int A_CAN  = 'h1B;
    localparam int A_FIFO = 'h24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0]   reg_addr = 12'(A_STS);
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic          eng_start, eng_cancel;
    logic [15:0]   eng_cmd_len;
    logic [PW-1:0] eng_cmd_raddr = '0;
    logic [7:0]    eng_cmd_rdata;
    logic          eng_rsp_we = 1'b0;
    logic [PW-1:0] eng_rsp_waddr = '0;
    logic [7:0]    eng_rsp_wdata = 8'h00;
    logic          eng_done = 1'b0;
    logic [15:0]   eng_rsp_len = 16'd0;

    always #(PERIOD/2) clk = ~clk;

    cmdport_top #(.DEPTH(DEPTH), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_cmd_len(eng_cmd_len),
        .eng_cmd_raddr(eng_cmd_raddr), .eng_cmd_rdata(eng_cmd_rdata),
        .eng_rsp_we(eng_rsp_we), .eng_rsp_waddr(eng_rsp_waddr),
        .eng_rsp_wdata(eng_rsp_wdata), .eng_done(eng_done), .eng_rsp_len(eng_rsp_len)
    );

    // ---------------- reference model ----------------
    int       mst;          // 0 idle, 1 receive, 2 execute, 3 readout
    int       mcnt;
    longint   mlen;
    int       mrlen, mrptr;
    bit       mstart, mcancel;
    bit [7:0] mcmd [DEPTH];
    bit [7:0] mrsp [DEPTH];

    int  n_chk = 0, n_fail = 0;
    bit  done_flag = 0;

    function automatic bit m_expect();
        return (mst == 1) && (mcnt != 0) && (mcnt < DEPTH) && ((mcnt < 6) || (mcnt < mlen));
    endfunction

    function automatic bit m_accept();
        return (mst == 1) && ((mcnt == 0) || m_expect());
    endfunction

    function automatic bit m_avail();
        return (mst == 3) && (mrptr < mrlen);
    endfunction

    function automatic int m_burst();
        if (m_accept()) return DEPTH - mcnt;
        if (mst == 3) return mrlen - mrptr;
        return 0;
    endfunction

    function automatic int m_read(int a);
        int s;
        if (a == A_STS) begin
            s = 'h80;
            if (mst == 1) s += 'h40;
            if (m_avail()) s += 'h10;
            if (m_expect()) s += 'h08;
            return s;
        end
        if (a == A_BL) return m_burst() % 256;
        if (a == A_BH) return m_burst() / 256;
        if (a == A_FIFO) return m_avail() ? int'(mrsp[mrptr]) : 0;
        return 0;
    endfunction

    task automatic model_reset();
        mst = 0; mcnt = 0; mlen = 0; mrlen = 0; mrptr = 0; mstart = 0; mcancel = 0;
        for (int i = 0; i < DEPTH; i++) begin mcmd[i] = 0; mrsp[i] = 0; end
    endtask

    task automatic model_update();
        int  a;
        bit  acc, exp_now, avail;
        int  nst, ncnt, nrptr;
        a = int'(reg_addr);
        acc = m_accept(); exp_now = m_expect(); avail = m_avail();
        nst = mst; ncnt = mcnt; nrptr = mrptr;
        mstart = 0; mcancel = 0;
        if (reg_wr && a == A_STS && reg_wdata[6]) begin
            nst = 1; ncnt = 0; mlen = 0;
        end else if (reg_wr && a == A_STS && reg_wdata[5]) begin
            if (mst == 1 && mcnt != 0 && !exp_now) begin nst = 2; mstart = 1; end
        end else if (reg_wr && a == A_STS && reg_wdata[1]) begin
            if (mst == 3) nrptr = 0;
        end
        if (reg_wr && a == A_FIFO && acc) begin
            mcmd[mcnt] = reg_wdata;
            if (mcnt >= 2 && mcnt <= 5) mlen = (mlen * 256 + reg_wdata) % 64'h1_0000_0000;
            ncnt = mcnt + 1;
        end
        if (reg_rd && a == A_FIFO && avail) nrptr = mrptr + 1;
        if (eng_rsp_we && mst == 2 && int'(eng_rsp_waddr) < DEPTH)
            mrsp[eng_rsp_waddr] = eng_rsp_wdata;
        if (mst == 2 && eng_done) begin
            nst = 3; nrptr = 0;
            mrlen = (int'(eng_rsp_len) > DEPTH) ? DEPTH : int'(eng_rsp_len);
        end
        if (reg_wr && a == A_CAN && reg_wdata[0] && mst == 2) begin
            nst = 0; mcancel = 1;
        end
        mst = nst; mcnt = ncnt; mrptr = nrptr;
    endtask

    // ---------------- checking ----------------
    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_for(int a);
        if (a == A_STS) return "R4";
        if (a == A_BL || a == A_BH) return "R5";
        if (a == A_FIFO) return "R8";
        return "R2";
    endfunction

    task automatic compare_all();
        chk(tag_for(int'(reg_addr)), int'(reg_rdata), m_read(int'(reg_addr)));
        chk("R6", int'(eng_start), int'(mstart));
        chk("R10", int'(eng_cancel), int'(mcancel));
        if (mst == 2) begin
            chk("R6", int'(eng_cmd_len), mcnt);
            if (int'(eng_cmd_raddr) < mcnt)
                chk("R12", int'(eng_cmd_rdata), int'(mcmd[eng_cmd_raddr]));
        end
    endtask

    task automatic tick();
        #(PERIOD/4);
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_addr = 12'(A_STS);
        eng_rsp_we = 0; eng_done = 0;
    endtask

    task automatic wr(int a, int v);
        reg_wr = 1; reg_addr = 12'(a); reg_wdata = 8'(v); tick();
    endtask

    task automatic fifo_pop();
        reg_rd = 1; reg_addr = 12'(A_FIFO); tick();
    endtask

    task automatic peek(int a, string tag, int exp);
        reg_addr = 12'(a);
        #1 chk(tag, int'(reg_rdata), exp);
        tick();
    endtask

    task automatic peek_burst(string tag, int exp);
        peek(A_BL, tag, exp % 256);
        peek(A_BH, tag, exp / 256);
    endtask

    function automatic int cmd_byte(int i, longint lenf);
        if (i == 0) return 'h80;
        if (i == 1) return 'h01;
        if (i <= 5) return int'((lenf >> (8 * (5 - i))) & 'hFF);
        return (i ^ 'h5A) & 'hFF;
    endfunction

    task automatic send_bytes(longint lenf, int from, int n);
        for (int i = from; i < from + n; i++) wr(A_FIFO, cmd_byte(i, lenf));
    endtask

    task automatic eng_fill(int n, int base);
        for (int i = 0; i < n; i++) begin
            eng_rsp_we = 1; eng_rsp_waddr = PW'(i); eng_rsp_wdata = 8'((base + i) & 'hFF);
            tick();
        end
    endtask

    task automatic eng_finish(int len);
        eng_done = 1; eng_rsp_len = 16'(len); tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got hang expected completion");
                finish_run();
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        peek(A_STS, "R1", 'h80);
        peek_burst("R1", 0);
        chk("R1", int'(eng_start), 0);
        chk("R1", int'(eng_cancel), 0);

        // R6 go ignored while idle, R3 FIFO write ignored while idle
        wr(A_STS, 'h20);
        wr(A_FIFO, 'h33);
        peek(A_STS, "R3", 'h80);

        // R2 ready; R5 full space
        wr(A_STS, 'h40);
        peek(A_STS, "R2", 'hC0);
        peek_burst("R5", DEPTH);

        // 10-byte command, length field 10
        send_bytes(10, 0, 1);
        peek(A_STS, "R4", 'hC8);
        peek_burst("R5", DEPTH - 1);
        send_bytes(10, 1, 2);
        wr(A_STS, 'h20);                       // R6 go ignored while expect=1
        peek(A_STS, "R6", 'hC8);
        send_bytes(10, 3, 7);
        peek(A_STS, "R4", 'hC0);
        peek_burst("R5", 0);
        wr(A_FIFO, 'hEE);                      // R3 ignored once complete
        peek(A_STS, "R3", 'hC0);

        // R6 go
        wr(A_STS, 'h20);
        chk("R6", int'(eng_start), 1);
        chk("R6", int'(eng_cmd_len), 10);
        for (int i = 0; i < 10; i++) begin
            eng_cmd_raddr = PW'(i);
            #1 chk("R12", int'(eng_cmd_rdata), cmd_byte(i, 10));
            tick();
        end
        peek(A_STS, "R7", 'h80);
        peek_burst("R7", 0);

        // response of 12 bytes
        eng_fill(12, 'hA0);
        eng_finish(12);
        peek(A_STS, "R8", 'h90);
        peek_burst("R8", 12);
        for (int i = 0; i < 5; i++) fifo_pop();
        peek_burst("R8", 7);
        peek(A_FIFO, "R8", 'hA5);
        wr(A_STS, 'h02);                       // R9 rewind
        peek_burst("R9", 12);
        peek(A_FIFO, "R9", 'hA0);
        for (int i = 0; i < 12; i++) fifo_pop();
        peek(A_STS, "R8", 'h80);
        peek_burst("R8", 0);
        fifo_pop();
        peek(A_FIFO, "R8", 0);

        // R11 ready wins over go and retry
        wr(A_STS, 'h62);
        peek(A_STS, "R11", 'hC0);
        peek_burst("R11", DEPTH);

        // R9 retry ignored in reception
        send_bytes(2, 0, 3);
        wr(A_STS, 'h02);
        peek_burst("R9", DEPTH - 3);

        // R4 short length field: header of 6 still required
        send_bytes(2, 3, 2);
        peek(A_STS, "R4", 'hC8);
        send_bytes(2, 5, 1);
        peek(A_STS, "R4", 'hC0);

        // R4 length beyond depth: expect falls when buffer full
        wr(A_STS, 'h40);
        send_bytes(64'hFFFF, 0, DEPTH - 1);
        peek(A_STS, "R4", 'hC8);
        peek_burst("R5", 1);
        send_bytes(64'hFFFF, DEPTH - 1, 1);
        peek(A_STS, "R4", 'hC0);
        wr(A_STS, 'h20);
        chk("R6", int'(eng_cmd_len), DEPTH);

        // R7 response length clamp
        eng_fill(DEPTH, 'h10);
        eng_finish(2000);
        peek_burst("R7", DEPTH);
        peek(A_STS, "R7", 'h90);

        // R10 cancel ignored in readout
        wr(A_CAN, 'h01);
        peek(A_STS, "R10", 'h90);

        // R10 cancel during execution
        wr(A_STS, 'h40);
        send_bytes(6, 0, 6);
        wr(A_STS, 'h20);
        wr(A_CAN, 'h01);
        chk("R10", int'(eng_cancel), 1);
        peek(A_STS, "R10", 'h80);
        peek_burst("R10", 0);

        // R7 engine writes ignored outside execution
        eng_fill(1, 'h77);
        wr(A_STS, 'h40);
        send_bytes(6, 0, 6);
        wr(A_STS, 'h20);
        eng_finish(1);
        peek(A_FIFO, "R7", 'h10);

        repeat (2) tick();
        finish_run();
    end

endmodule